// File: doc/BRIEF.md
# Three-Read Two-Write Register File on Two-Port Storage

This block is a register file with two write ports and three read ports. Its storage is plain inferred memory with one write port and one read port. Every read port has its own full copy of the register contents. Every write goes to all three copies. A copy has only one write port, so the two writes are applied one after the other. Each architectural cycle therefore spans three clocks: accept and first write, second write, then read.

A pipeline uses `ready` as its stall signal. On a rising edge where `ready` is high, the block takes in both write requests and all three read addresses. It then drops `ready` for two clocks. When `ready` rises again, the three read outputs hold the operands for the cycle just finished. Both writes of that cycle are already visible in those operands, so a value written in a cycle can be read back in the same cycle. Because each edge with `ready` high starts a new cycle, a caller with nothing to write simply drives both enables low.

Top module: `rf3r2w`

## Requirements
- R1: While reset is held, `ready` is 1 and all three read outputs are 0.
- R2: Every rising edge with `ready` high accepts a cycle. `ready` is then 0 for exactly two clocks and returns to 1 on the third edge after acceptance.
- R3: The read outputs change only on the edge where `ready` returns to 1. While `ready` is 0 they keep the operands of the previous cycle.
- R4: A read whose address matches a register written in the same cycle returns the newly written value.
- R5: If both write ports are enabled for the same register, the value from write port 1 is the one stored.
- R6: Values on any input while `ready` is 0 have no effect. No register is written, and the read outputs show the registers named by the read addresses captured at acceptance.
- R7: A write port with its enable at 0 leaves every register unchanged.
- R8: The three read ports work independently. Any combination of addresses is allowed, including the same register on all three. Register 0 stores and returns values like any other register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wrEn0 | input | 1 | Write port 0 enable |
| wrAddr0 | input | 4 | Write port 0 register index |
| wrData0 | input | 16 | Write port 0 data |
| wrEn1 | input | 1 | Write port 1 enable (wins on same index) |
| wrAddr1 | input | 4 | Write port 1 register index |
| wrData1 | input | 16 | Write port 1 data |
| rdAddr0 | input | 4 | Read port 0 register index |
| rdAddr1 | input | 4 | Read port 1 register index |
| rdAddr2 | input | 4 | Read port 2 register index |
| rdData0 | output | 16 | Read port 0 operand |
| rdData1 | output | 16 | Read port 1 operand |
| rdData2 | output | 16 | Read port 2 operand |
| ready | output | 1 | High when a new cycle can be accepted and operands are valid |

## Verification
Call the accepting edge E0.

- **`ready`:** it is due low after E0 and after E0+1, and high again after E0+2.
- **Read operands:** they are due after E0+2. They must hold their old values at both busy samples.

The bench drives inputs and samples outputs on falling edges. It checks `ready` at each of the three falling edges that follow acceptance. It compares the operands against its own register model only at the third falling edge, after applying write port 0 and then write port 1 to that model. Random values are driven on every input during the busy clocks, so any leak of those values shows up in the later operands.

// File: rtl/rf3r2w_pkg.sv
`timescale 1ns/1ps
package rf3r2w_pkg;

  // Internal sequence of one architectural cycle
  typedef enum logic [1:0] {
    PH_ACCEPT = 2'd0,  // ready high; first write from the ports
    PH_SECOND = 2'd1,  // second write from the held request
    PH_READ   = 2'd2   // all copies read in parallel
  } rfPhase_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic acceptNow;
    logic commitSecond;
    logic readNow;
  } rfStrobe_t;

endpackage

// File: rtl/rf_bank.sv
`timescale 1ns/1ps
module rf_bank #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [AW-1:0]    wrAddr,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdEn,
  input  logic [AW-1:0]    rdAddr,
  output logic [WIDTH-1:0] rdData
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (rst)       rdData <= '0;
    else if (rdEn) rdData <= mem[rdAddr];
  end

endmodule

// File: rtl/rf_ctrl.sv
`timescale 1ns/1ps
module rf_ctrl
  import rf3r2w_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  output rfStrobe_t strobe,
  output logic      ready
);

  rfPhase_t phase, phaseNext;

  always_comb begin
    unique case (phase)
      PH_ACCEPT: phaseNext = PH_SECOND;
      PH_SECOND: phaseNext = PH_READ;
      PH_READ:   phaseNext = PH_ACCEPT;
      default:   phaseNext = PH_ACCEPT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_ACCEPT;
    else     phase <= phaseNext;
  end

  always_comb begin
    strobe.acceptNow    = (phase == PH_ACCEPT);
    strobe.commitSecond = (phase == PH_SECOND);
    strobe.readNow      = (phase == PH_READ);
    ready               = (phase == PH_ACCEPT);
  end

endmodule

// File: rtl/rf_datapath.sv
`timescale 1ns/1ps
module rf_datapath
  import rf3r2w_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int DEPTH = 16,
  parameter int READS = 3,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  rfStrobe_t                   strobe,
  input  logic [1:0]                  wrEn,
  input  logic [1:0][AW-1:0]          wrAddr,
  input  logic [1:0][WIDTH-1:0]       wrData,
  input  logic [READS-1:0][AW-1:0]    rdAddr,
  output logic [READS-1:0][WIDTH-1:0] rdData
);

  // Request held across the busy phases
  logic                    heldEn1;
  logic [AW-1:0]           heldAddr1;
  logic [WIDTH-1:0]        heldData1;
  logic [READS-1:0][AW-1:0] heldRdAddr;

  always_ff @(posedge clk) begin
    if (rst) begin
      heldEn1    <= 1'b0;
      heldAddr1  <= '0;
      heldData1  <= '0;
      heldRdAddr <= '0;
    end else if (strobe.acceptNow) begin
      heldEn1    <= wrEn[1];
      heldAddr1  <= wrAddr[1];
      heldData1  <= wrData[1];
      heldRdAddr <= rdAddr;
    end
  end

  // Shared write bus: port 0 live at acceptance, port 1 one phase later
  logic             bankWrEn;
  logic [AW-1:0]    bankWrAddr;
  logic [WIDTH-1:0] bankWrData;

  always_comb begin
    bankWrEn   = (strobe.acceptNow & wrEn[0]) | (strobe.commitSecond & heldEn1);
    bankWrAddr = strobe.acceptNow ? wrAddr[0] : heldAddr1;
    bankWrData = strobe.acceptNow ? wrData[0] : heldData1;
  end

  for (genvar i = 0; i < READS; i++) begin : g_copy
    rf_bank #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_bank (
      .clk    (clk),
      .rst    (rst),
      .wrEn   (bankWrEn),
      .wrAddr (bankWrAddr),
      .wrData (bankWrData),
      .rdEn   (strobe.readNow),
      .rdAddr (heldRdAddr[i]),
      .rdData (rdData[i])
    );
  end

endmodule

// File: rtl/rf3r2w.sv
`timescale 1ns/1ps
module rf3r2w
  import rf3r2w_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn0,
  input  logic [AW-1:0]    wrAddr0,
  input  logic [WIDTH-1:0] wrData0,
  input  logic             wrEn1,
  input  logic [AW-1:0]    wrAddr1,
  input  logic [WIDTH-1:0] wrData1,
  input  logic [AW-1:0]    rdAddr0,
  input  logic [AW-1:0]    rdAddr1,
  input  logic [AW-1:0]    rdAddr2,
  output logic [WIDTH-1:0] rdData0,
  output logic [WIDTH-1:0] rdData1,
  output logic [WIDTH-1:0] rdData2,
  output logic             ready
);

  localparam int READS = 3;

  rfStrobe_t                   strobe;
  logic [READS-1:0][WIDTH-1:0] rdBus;

  rf_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .ready  (ready)
  );

  rf_datapath #(.WIDTH(WIDTH), .DEPTH(DEPTH), .READS(READS)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .wrEn   ({wrEn1, wrEn0}),
    .wrAddr ({wrAddr1, wrAddr0}),
    .wrData ({wrData1, wrData0}),
    .rdAddr ({rdAddr2, rdAddr1, rdAddr0}),
    .rdData (rdBus)
  );

  assign rdData0 = rdBus[0];
  assign rdData1 = rdBus[1];
  assign rdData2 = rdBus[2];

endmodule

// File: rtl/rf3r2w_checker.sv
`timescale 1ns/1ps
module rf3r2w_checker #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             ready,
  input logic [WIDTH-1:0] rdData0,
  input logic [WIDTH-1:0] rdData1,
  input logic [WIDTH-1:0] rdData2
);

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (ready && rdData0 == '0 && rdData1 == '0 && rdData2 == '0));

  p_accept_drops_r2: assert property (@(posedge clk) disable iff (rst)
    ready |=> !ready);

  p_busy_second_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(ready) |=> !ready);

  p_busy_ends_r2: assert property (@(posedge clk) disable iff (rst)
    (!ready && $past(!ready)) |=> ready);

  p_hold_operands_r3: assert property (@(posedge clk) disable iff (rst)
    !ready |-> ($stable(rdData0) && $stable(rdData1) && $stable(rdData2)));

endmodule

bind rf3r2w rf3r2w_checker #(.WIDTH(WIDTH)) u_checker (
  .clk     (clk),
  .rst     (rst),
  .ready   (ready),
  .rdData0 (rdData0),
  .rdData1 (rdData1),
  .rdData2 (rdData2)
);

// File: tb/tb_rf3r2w.sv
`timescale 1ns/1ps
module tb_rf3r2w;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn0 = 0, wrEn1 = 0;
  logic [3:0]  wrAddr0 = 0, wrAddr1 = 0, rdAddr0 = 0, rdAddr1 = 0, rdAddr2 = 0;
  logic [15:0] wrData0 = 0, wrData1 = 0;
  logic [15:0] rdData0, rdData1, rdData2;
  logic        ready;

  int checks = 0;
  int fails  = 0;
  logic [15:0] model [16];
  logic [15:0] prevRd [3];

  always #10 clk = ~clk;

  rf3r2w dut (
    .clk(clk), .rst(rst),
    .wrEn0(wrEn0), .wrAddr0(wrAddr0), .wrData0(wrData0),
    .wrEn1(wrEn1), .wrAddr1(wrAddr1), .wrData1(wrData1),
    .rdAddr0(rdAddr0), .rdAddr1(rdAddr1), .rdAddr2(rdAddr2),
    .rdData0(rdData0), .rdData1(rdData1), .rdData2(rdData2),
    .ready(ready)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] expRead(input logic [3:0] a);
    return model[a];
  endfunction

  task automatic noiseInputs();
    wrEn0 = 1'($urandom); wrAddr0 = 4'($urandom); wrData0 = 16'($urandom);
    wrEn1 = 1'($urandom); wrAddr1 = 4'($urandom); wrData1 = 16'($urandom);
    rdAddr0 = 4'($urandom); rdAddr1 = 4'($urandom); rdAddr2 = 4'($urandom);
  endtask

  task automatic checkHeld(input string tag);
    check(tag, rdData0, prevRd[0]);
    check(tag, rdData1, prevRd[1]);
    check(tag, rdData2, prevRd[2]);
  endtask

  // One architectural cycle; caller is at a falling edge
  task automatic doCycle(input logic e0, input logic [3:0] a0, input logic [15:0] d0,
                         input logic e1, input logic [3:0] a1, input logic [15:0] d1,
                         input logic [3:0] r0, input logic [3:0] r1, input logic [3:0] r2,
                         input bit noise, input string tag);
    while (!ready) @(negedge clk);
    wrEn0 = e0; wrAddr0 = a0; wrData0 = d0;
    wrEn1 = e1; wrAddr1 = a1; wrData1 = d1;
    rdAddr0 = r0; rdAddr1 = r1; rdAddr2 = r2;
    @(negedge clk);
    check("R2 busy1", 16'(ready), 16'(0));
    checkHeld("R3 hold1");
    if (noise) noiseInputs();
    @(negedge clk);
    check("R2 busy2", 16'(ready), 16'(0));
    checkHeld("R3 hold2");
    if (noise) noiseInputs();
    @(negedge clk);
    check("R2 back", 16'(ready), 16'(1));
    if (e0) model[a0] = d0;
    if (e1) model[a1] = d1;
    prevRd[0] = expRead(r0); prevRd[1] = expRead(r1); prevRd[2] = expRead(r2);
    check(tag, rdData0, prevRd[0]);
    check(tag, rdData1, prevRd[1]);
    check(tag, rdData2, prevRd[2]);
    wrEn0 = 0; wrEn1 = 0;
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'h1357_2468));
    for (int i = 0; i < 3; i++) prevRd[i] = 16'h0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 ready", 16'(ready), 16'(1));
    check("R1 rd0", rdData0, 16'h0);
    check("R1 rd1", rdData1, 16'h0);
    check("R1 rd2", rdData2, 16'h0);
    rst = 0;

    // Fill all registers, two per cycle
    for (int i = 0; i < 8; i++)
      doCycle(1, 4'(2*i), 16'($urandom), 1, 4'(2*i+1), 16'($urandom),
              4'(2*i), 4'(2*i+1), 4'(2*i), 0, "R4 fill");

    // R4 write-before-read on both ports
    doCycle(1, 4'd5, 16'hA5A5, 1, 4'd9, 16'h5A5A, 4'd5, 4'd9, 4'd5, 0, "R4 same-cycle");
    // R5 collision: port 1 wins
    doCycle(1, 4'd7, 16'h1111, 1, 4'd7, 16'h2222, 4'd7, 4'd7, 4'd3, 0, "R5 collide");
    check("R5 value", rdData0, 16'h2222);
    // R7 disabled ports
    doCycle(0, 4'd3, 16'hDEAD, 0, 4'd4, 16'hBEEF, 4'd3, 4'd4, 4'd7, 0, "R7 disabled");
    // R8 register 0 on all three ports
    doCycle(1, 4'd0, 16'hC0DE, 0, 4'd0, 16'h0, 4'd0, 4'd0, 4'd0, 0, "R8 reg0");
    check("R8 reg0 value", rdData2, 16'hC0DE);
    // R6 noise during busy, then sweep
    doCycle(0, 4'd0, 16'h0, 0, 4'd0, 16'h0, 4'd1, 4'd2, 4'd3, 1, "R6 captured addr");
    for (int i = 0; i < 16; i += 3)
      doCycle(0, 0, 0, 0, 0, 0, 4'(i), 4'((i+1)%16), 4'((i+2)%16), 1, "R6 sweep");

    // Random mix
    for (int n = 0; n < 300; n++) begin
      logic [3:0] a0, a1;
      a0 = 4'($urandom);
      a1 = ($urandom % 4 == 0) ? a0 : 4'($urandom);
      doCycle(1'($urandom), a0, 16'($urandom), 1'($urandom), a1, 16'($urandom),
              ($urandom % 3 == 0) ? a1 : 4'($urandom), 4'($urandom),
              ($urandom % 3 == 0) ? a0 : 4'($urandom), 1'($urandom), "R8 random");
    end

    for (int i = 0; i < 16; i++)
      doCycle(0, 0, 0, 0, 0, 0, 4'(i), 4'(i), 4'(i), 1, "R6 final sweep");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule